// File: doc/BRIEF.md
# PHY ADC Sample Accumulator

This block runs one analog-test measurement on a serial-link PHY through that PHY's four-phase control-register port. After a start request it points the PHY at its tuning-control register, loads a caller-supplied tuning word there, and then reads the PHY's ADC output register again and again. Each ADC read carries a valid flag next to a 10-bit sample. The block first throws reads away until the flag appears. It then adds up the payload of flagged reads until a fixed number of samples has been gathered. Finally it scales the sum by 1000/80, which gives the 80-sample average at milli-unit resolution.

Both phases have a bound on the number of reads. If a phase runs past that bound, the measurement stops with a one-cycle error pulse and the previous result is kept. A good measurement ends with a one-cycle done pulse, and the new result is already valid in that cycle. A controller, such as a temperature-monitor sequencer, starts a measurement and waits for one of the two pulses.

Top module: `phy_adc_accum`

## Requirements
- R1: After start, the block captures address 0x0009, then captures the tuning word as data, then issues a write strobe, so that the PHY's register 0x0009 holds the tuning word before any ADC read.
- R2: Every ADC read is issued while the PHY address is 0x000A, and this address is captured once, after the tuning write.
- R3: Each control-port access raises exactly one strobe. The strobe is raised only while ack is low and held until ack goes high. It is dropped after that, and the next strobe waits for ack to return low. The data bus stays stable while a strobe is high.
- R4: In the seek phase, reads whose bit 10 is 0 are discarded. The first read with bit 10 set ends the phase, and its sample is not summed.
- R5: The seek phase fails when the number of unflagged reads exceeds 200: 200 unflagged reads followed by a flagged one succeed, and 201 unflagged reads give an error.
- R6: In the sum phase, only reads with bit 10 set contribute, and only bits 9:0 are added. Bits 15:11 and unflagged reads have no effect on the result.
- R7: The sum phase counts every read from zero. If the count exceeds 200, the result is an error, even on the read that would complete the 80th sample. 80 samples gathered within exactly 200 reads succeed.
- R8: On success, result equals floor(sum × 1000 / 80). done is a one-cycle pulse in the cycle the result first shows the new value, and result changes at no other time.
- R9: On failure, error is a one-cycle pulse. done does not pulse, and result keeps its previous value.
- R10: A start request while a measurement is in progress is ignored.
- R11: After reset, result is 0 and done, error and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one measurement (accepted when idle) |
| tune_word | input | 16 | Word written to the tuning-control register |
| phy_wdata | output | 16 | Address or data presented to the PHY control port |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_write | output | 1 | Write strobe |
| phy_read | output | 1 | Read strobe |
| phy_ack | input | 1 | PHY acknowledge for the active strobe |
| phy_rdata | input | 16 | PHY read data, valid while ack is high during a read |
| result | output | 32 | Scaled average from the last good measurement |
| done | output | 1 | One-cycle pulse: measurement finished, result updated |
| error | output | 1 | One-cycle pulse: read limit exceeded |

## Verification
Two events can fall in the same cycle: the sum phase can reach its 80th flagged sample on the very read where its read count first goes past 200. The bench sets this up by scripting 121 unflagged reads before 80 flagged ones. The block is judged correct only if it answers with the error pulse, gives no done, and leaves the old result. A neighbouring script with 120 unflagged reads must still complete, which confirms that the bound sits exactly at 200.

// File: rtl/phy_meas_pkg.sv
package phy_meas_pkg;
  typedef enum logic [1:0] {
    HS_CAP_ADDR = 2'd0,
    HS_CAP_DATA = 2'd1,
    HS_WRITE    = 2'd2,
    HS_READ     = 2'd3
  } hs_op_e;

  typedef enum logic [2:0] {
    M_IDLE, M_TADDR, M_TDATA, M_TWR, M_AADDR, M_SEEK, M_SUM, M_DIV
  } meas_st_e;
endpackage

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_meas_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  hs_op_e        op,
  input  logic [DW-1:0] wdata,
  input  logic          ack,
  input  logic [DW-1:0] rdin,
  output logic [3:0]    strb,
  output logic [DW-1:0] bus,
  output logic [DW-1:0] rdata,
  output logic          done
);
  typedef enum logic [1:0] {H_IDLE, H_UP, H_DN} hs_st_e;
  hs_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= H_IDLE;
      strb  <= '0;
      bus   <= '0;
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        H_IDLE: if (req && !ack) begin
          strb <= 4'b0001 << op;
          if (op == HS_CAP_ADDR || op == HS_CAP_DATA) bus <= wdata;
          st <= H_UP;
        end
        H_UP: if (ack) begin
          if (strb[HS_READ]) rdata <= rdin;
          strb <= '0;
          st   <= H_DN;
        end
        default: if (!ack) begin
          done <= 1'b1;
          st   <= H_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/seq_udiv.sv
module seq_udiv #(
  parameter int W  = 32,
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  num,
  input  logic [DW-1:0] den,
  output logic [W-1:0]  quo,
  output logic          done
);
  localparam int CW = $clog2(W + 1);

  logic [DW-1:0] rem;
  logic [W-1:0]  q;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [DW:0]   shifted;

  assign shifted = {rem, q[W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0; q <= '0; cnt <= '0; busy <= 1'b0; quo <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        rem  <= '0;
        q    <= num;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        if (shifted >= {1'b0, den}) begin
          rem <= DW'(shifted - {1'b0, den});
          q   <= {q[W-2:0], 1'b1};
        end else begin
          rem <= shifted[DW-1:0];
          q   <= {q[W-2:0], 1'b0};
        end
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          quo  <= (shifted >= {1'b0, den}) ? {q[W-2:0], 1'b1} : {q[W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/phy_adc_accum.sv
module phy_adc_accum
  import phy_meas_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          SAMPLE_W  = 10,
  parameter int          VALID_BIT = 10,
  parameter int          SAMPLES   = 80,
  parameter int          LIMIT     = 200,
  parameter int          SCALE     = 1000,
  parameter int          RES_W     = 32,
  parameter logic [15:0] TUNE_ADDR = 16'h0009,
  parameter logic [15:0] ADC_ADDR  = 16'h000A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DW-1:0]    tune_word,
  output logic [DW-1:0]    phy_wdata,
  output logic             phy_cap_addr,
  output logic             phy_cap_data,
  output logic             phy_write,
  output logic             phy_read,
  input  logic             phy_ack,
  input  logic [DW-1:0]    phy_rdata,
  output logic [RES_W-1:0] result,
  output logic             done,
  output logic             error
);
  localparam int SUM_W = $clog2(SAMPLES * ((1 << SAMPLE_W) - 1) + 1);
  localparam int ATT_W = $clog2(LIMIT + 2);
  localparam int N_W   = $clog2(SAMPLES + 1);
  localparam int DEN_W = $clog2(SAMPLES + 1);

  meas_st_e         st;
  logic             pend, hs_req, hs_done;
  hs_op_e           hs_op;
  logic [DW-1:0]    hs_wdata, hs_rdata, tune_q;
  logic [3:0]       strb;
  logic [ATT_W-1:0] att;
  logic [ATT_W-1:0] att_nxt;
  logic [N_W-1:0]   nsmp;
  logic [SUM_W-1:0] sum;
  logic             rd_valid, div_start, div_done;
  logic [RES_W-1:0] div_q;

  assign att_nxt  = att + 1'b1;
  assign rd_valid = hs_rdata[VALID_BIT];

  always_comb begin
    hs_op    = HS_READ;
    hs_wdata = '0;
    case (st)
      M_TADDR: begin hs_op = HS_CAP_ADDR; hs_wdata = DW'(TUNE_ADDR); end
      M_TDATA: begin hs_op = HS_CAP_DATA; hs_wdata = tune_q; end
      M_TWR:   hs_op = HS_WRITE;
      M_AADDR: begin hs_op = HS_CAP_ADDR; hs_wdata = DW'(ADC_ADDR); end
      default: hs_op = HS_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= M_IDLE; pend <= 1'b0; hs_req <= 1'b0; tune_q <= '0;
      att <= '0; nsmp <= '0; sum <= '0; div_start <= 1'b0;
      result <= '0; done <= 1'b0; error <= 1'b0;
    end else begin
      hs_req    <= 1'b0;
      div_start <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      if (st != M_IDLE && st != M_DIV && !pend) begin
        hs_req <= 1'b1;
        pend   <= 1'b1;
      end
      case (st)
        M_IDLE: if (start) begin
          tune_q <= tune_word;
          st     <= M_TADDR;
        end
        M_TADDR: if (hs_done) begin pend <= 1'b0; st <= M_TDATA; end
        M_TDATA: if (hs_done) begin pend <= 1'b0; st <= M_TWR; end
        M_TWR:   if (hs_done) begin pend <= 1'b0; st <= M_AADDR; end
        M_AADDR: if (hs_done) begin pend <= 1'b0; att <= '0; st <= M_SEEK; end
        M_SEEK: if (hs_done) begin
          pend <= 1'b0;
          if (rd_valid) begin
            att <= '0; nsmp <= '0; sum <= '0; st <= M_SUM;
          end else if (att_nxt > ATT_W'(LIMIT)) begin
            error <= 1'b1; st <= M_IDLE;
          end else begin
            att <= att_nxt;
          end
        end
        M_SUM: if (hs_done) begin
          pend <= 1'b0;
          att  <= att_nxt;
          if (rd_valid) begin
            sum  <= sum + SUM_W'(hs_rdata[SAMPLE_W-1:0]);
            nsmp <= nsmp + 1'b1;
          end
          if (att_nxt > ATT_W'(LIMIT)) begin
            error <= 1'b1; st <= M_IDLE;
          end else if (rd_valid && nsmp == N_W'(SAMPLES - 1)) begin
            div_start <= 1'b1; st <= M_DIV;
          end
        end
        default: if (div_done) begin
          result <= div_q;
          done   <= 1'b1;
          st     <= M_IDLE;
        end
      endcase
    end
  end

  phy_cr_master #(.DW(DW)) u_hs (
    .clk(clk), .rst(rst), .req(hs_req), .op(hs_op), .wdata(hs_wdata),
    .ack(phy_ack), .rdin(phy_rdata), .strb(strb), .bus(phy_wdata),
    .rdata(hs_rdata), .done(hs_done)
  );

  seq_udiv #(.W(RES_W), .DW(DEN_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start),
    .num(RES_W'(sum) * RES_W'(SCALE)), .den(DEN_W'(SAMPLES)),
    .quo(div_q), .done(div_done)
  );

  assign phy_cap_addr = strb[HS_CAP_ADDR];
  assign phy_cap_data = strb[HS_CAP_DATA];
  assign phy_write    = strb[HS_WRITE];
  assign phy_read     = strb[HS_READ];
endmodule

// File: rtl/phy_adc_accum_chk.sv
module phy_adc_accum_chk #(
  parameter int DW    = 16,
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [DW-1:0]    phy_wdata,
  input logic             phy_cap_addr,
  input logic             phy_cap_data,
  input logic             phy_write,
  input logic             phy_read,
  input logic             phy_ack,
  input logic [RES_W-1:0] result,
  input logic             done,
  input logic             error
);
  logic any_strb;
  assign any_strb = phy_cap_addr | phy_cap_data | phy_write | phy_read;

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({phy_cap_addr, phy_cap_data, phy_write, phy_read}));
  // R3
  strobe_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(phy_cap_addr) || $fell(phy_cap_data) || $fell(phy_write) || $fell(phy_read))
      |-> $past(phy_ack));
  // R3
  strobe_raise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(any_strb) |-> !$past(phy_ack));
  // R3
  bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (any_strb && $past(any_strb)) |-> $stable(phy_wdata));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    error |-> $stable(result));
  // R8
  result_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);
endmodule

bind phy_adc_accum phy_adc_accum_chk #(.DW(DW), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .phy_wdata(phy_wdata), .phy_cap_addr(phy_cap_addr),
  .phy_cap_data(phy_cap_data), .phy_write(phy_write), .phy_read(phy_read),
  .phy_ack(phy_ack), .result(result), .done(done), .error(error)
);

// File: tb/phy_adc_accum_tb.sv
module phy_adc_accum_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] tune_word = '0;
  logic [15:0] phy_wdata, phy_rdata;
  logic        phy_cap_addr, phy_cap_data, phy_write, phy_read, phy_ack;
  logic [31:0] result;
  logic        done, error;

  always #10 clk = ~clk;

  phy_adc_accum u_dut (
    .clk(clk), .rst(rst), .start(start), .tune_word(tune_word),
    .phy_wdata(phy_wdata), .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
    .phy_write(phy_write), .phy_read(phy_read), .phy_ack(phy_ack),
    .phy_rdata(phy_rdata), .result(result), .done(done), .error(error)
  );

  // PHY model: scripted ADC stream
  int w_inv = 0, g2 = 0, seed = 0, step = 0;
  logic        m_clr = 1'b0;
  logic        m_ack = 1'b0;
  logic [15:0] m_dout = '0, m_addr = '0, m_data = '0, m_reg9 = '0;
  int          m_r = 0, m_bad = 0, m_wr9 = 0, m_early = 0, m_aaddr = 0;
  assign phy_ack   = m_ack;
  assign phy_rdata = m_dout;

  function automatic logic [15:0] adc_val(int r);
    int j;
    if (r < w_inv) return {5'b11111, 1'b0, 10'(r | 1)};
    if (r == w_inv) return {5'b11111, 1'b1, 10'h3FF};
    j = r - w_inv - 1;
    if (j < g2) return {5'b10101, 1'b0, 10'h2AA};
    return {5'b10110, 1'b1, 10'((seed + (j - g2) * step) & 1023)};
  endfunction

  always @(posedge clk) begin
    if (m_clr) begin
      m_r <= 0; m_bad <= 0; m_wr9 <= 0; m_early <= 0; m_aaddr <= 0; m_reg9 <= '0;
    end else if ((phy_cap_addr | phy_cap_data | phy_write | phy_read) && !m_ack) begin
      m_ack <= 1'b1;
      if (phy_cap_addr) begin
        m_addr <= phy_wdata;
        if (phy_wdata == 16'h000A) m_aaddr <= m_aaddr + 1;
      end
      if (phy_cap_data) m_data <= phy_wdata;
      if (phy_write && m_addr == 16'h0009) begin m_reg9 <= m_data; m_wr9 <= m_wr9 + 1; end
      if (phy_read) begin
        if (m_addr == 16'h000A) begin
          m_dout <= adc_val(m_r);
          m_r <= m_r + 1;
          if (m_wr9 == 0) m_early <= m_early + 1;
        end else begin
          m_bad <= m_bad + 1;
          m_dout <= 16'hFFFF;
        end
      end
    end else if (!(phy_cap_addr | phy_cap_data | phy_write | phy_read)) begin
      m_ack <= 1'b0;
    end
  end

  int total = 0, bad = 0;
  bit ended = 0;
  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    wrap_up();
  end

  typedef struct packed {
    int unsigned w;
    int unsigned g2;
    int unsigned seed;
    int unsigned step;
    logic [15:0] tune;
    logic        err;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{0,   0,   5,    37, 16'h1234, 1'b0},
    '{3,   7,   1000, 13, 16'h5A5A, 1'b0},
    '{200, 0,   1023, 0,  16'h0001, 1'b0},
    '{201, 0,   1,    3,  16'hBEEF, 1'b1},
    '{0,   120, 77,   91, 16'h0F0F, 1'b0},
    '{2,   121, 9,    5,  16'hC0DE, 1'b1},
    '{1,   4,   0,    0,  16'h7777, 1'b0}
  };

  int nd, ne;
  task automatic run_meas(input vec_t v, input bit restart_mid);
    w_inv = int'(v.w); g2 = int'(v.g2); seed = int'(v.seed); step = int'(v.step);
    @(negedge clk); m_clr = 1'b1;
    @(negedge clk); m_clr = 1'b0;
    tune_word = v.tune; start = 1'b1;
    @(negedge clk); start = 1'b0;
    nd = 0; ne = 0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (restart_mid && c == 40) begin
        tune_word = 16'hFFFF; start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
      if (done) nd++;
      if (error) ne++;
      if (done || error) break;
    end
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (done) nd++;
      if (error) ne++;
    end
  endtask

  longint exp_sum, exp_res, last_res;
  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(result == 0, "R11 result", result, 0);
    chk(!done && !error, "R11 done/error", {done, error}, 0);
    chk(!(phy_cap_addr | phy_cap_data | phy_write | phy_read), "R11 strobes",
        {phy_cap_addr, phy_cap_data, phy_write, phy_read}, 0);
    rst = 1'b0;
    last_res = 0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      run_meas(v, 1'b0);
      exp_sum = 0;
      for (int k = 0; k < 80; k++) exp_sum += (v.seed + k * v.step) & 1023;
      exp_res = v.err ? last_res : (exp_sum * 1000) / 80;
      // R1 tuning word landed before reads
      chk(m_reg9 == v.tune && m_wr9 == 1, "R1 tune reg", m_reg9, v.tune);
      chk(m_early == 0, "R1 read before write", m_early, 0);
      // R2 reads only at ADC address
      chk(m_bad == 0 && m_aaddr == 1, "R2 read address", m_bad, 0);
      if (v.err) begin
        // R5 / R7 read limit, R9 error behaviour
        chk(ne == 1 && nd == 0, v.w > 200 ? "R5 seek limit" : "R7 sum limit", ne * 10 + nd, 10);
        chk(result == exp_res, "R9 result held", result, exp_res);
      end else begin
        // R4 R6 R8 result and single done
        chk(nd == 1 && ne == 0, "R8 done pulse", nd * 10 + ne, 10);
        chk(result == exp_res, "R4 R6 R8 result", result, exp_res);
        chk(m_r == int'(v.w) + 1 + int'(v.g2) + 80, "R7 read count", m_r,
            v.w + 1 + v.g2 + 80);
        last_res = exp_res;
      end
    end

    // R10 start during a running measurement is ignored
    run_meas(VECS[1], 1'b1);
    exp_sum = 0;
    for (int k = 0; k < 80; k++) exp_sum += (VECS[1].seed + k * VECS[1].step) & 1023;
    chk(nd == 1 && ne == 0, "R10 single done", nd, 1);
    chk(m_reg9 == VECS[1].tune && m_wr9 == 1, "R10 tune kept", m_reg9, VECS[1].tune);
    chk(result == (exp_sum * 1000) / 80, "R10 result", result, (exp_sum * 1000) / 80);

    // R11 reset again clears result
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(result == 0 && !done && !error, "R11 re-reset", result, 0);
    rst = 1'b0;
    wrap_up();
  end
endmodule